// File: doc/BRIEF.md
# Vector Packet Cluster Dispatcher

The dispatcher sits between a cluster's input FIFO and a group of vector processing units. Framed packets arrive one 64-bit beat at a time: a header beat, N data beats carrying a 32-bit word in their low half, and a tail beat whose low half must hold a fixed sync constant. The block parses each header and forwards the whole packet, header through tail, to one target. The target is either the unit named in the header or a unit picked by an arbiter that watches per-unit load. A packet is never split or interleaved.

Header routing uses bit 63 as the command flag and bit 62 as the software-route flag. Bits 61:58 hold the version, bits 57:50 the unit number and bits 9:0 the data length N. Software-routed data packets and command packets go to the named unit. A command naming unit 0xFF goes to every unit at once. All other packets, and named packets whose unit number is out of range, are arbitrated. The arbiter runs one of three policies, picked by a two-bit input, and skips units that a per-unit watchdog has declared failed. Per-unit load, packet and word counters and the failed flags are visible on a small status port.

Forwarding is cut-through and holds no data. A beat moves only when every targeted unit is ready, so the input is stalled while any target holds back.

Top module: `ldb_dispatcher`

## Requirements
- R1: While idle, an input beat whose bits 61:58 differ from the header version HDR_VER (default 4'h5) is consumed and dropped: in_ready_o is high and no unit_valid_o bit rises.
- R2: A data header with bit 62 set and bits 57:50 below NU goes to that unit. The header beat is offered on unit_valid_o exactly one cycle after it first appears on the input.
- R3: A command header (bit 63 set) goes to the named unit with no arbitration. If bits 57:50 are 0xFF it goes to all units at once.
- R4: With policy_i = 0 (static), an arbitrated packet goes to the lowest-index non-failed unit, whatever the load and the header's unit field.
- R5: With policy_i = 1 (dynamic), an arbitrated packet goes to the non-failed unit with the lowest load, and ties go to the lower index.
- R6: With policy_i = 2 (round-robin), an arbitrated packet goes to the first non-failed unit after the one granted last by arbitration. The pointer moves only when that packet's tail is transferred.
- R7: The target set holds from the header until the tail. A beat transfers only when all targets are ready. Otherwise in_ready_o and unit_valid_o stay low.
- R8: A unit's load rises by one when a packet with a correct tail is delivered to it, and falls by one on each unit_done_i pulse. It never goes below zero.
- R9: While a unit's load is non-zero, its watchdog counts cycles with no accepted word. When the count reaches wd_limit_i, failed_o for that unit is set. A failed unit is excluded from arbitration until fail_clr_i clears it.
- R10: A tail whose low 32 bits differ from SYNC (default 32'hA5A5_5A5A) pulses framing_err_o for one cycle after the transfer and increments err_cnt_o. It leaves the unit's load and packet count unchanged, and the block returns to header search.
- R11: Per-unit packet and word counters (CNT_W bits) count good packets and accepted beats, and they saturate at all ones.
- R12: stat_sel_i selects which unit's packet count, word count and load appear on the stat outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Arbitration policy: 0 static, 1 dynamic, 2 round-robin |
| wd_limit_i | input | WD_W | Watchdog limit in cycles |
| fail_clr_i | input | NU | Per-unit clear of the failed flag |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted |
| in_data_i | input | 64 | Input beat |
| unit_valid_o | output | NU | Per-unit beat valid, high only on transfer |
| unit_ready_i | input | NU | Per-unit ready |
| unit_data_o | output | 64 | Beat shared by all units |
| unit_done_i | input | NU | Per-unit packet-completed pulse |
| failed_o | output | NU | Per-unit failed flags |
| framing_err_o | output | 1 | One-cycle pulse after a bad tail |
| err_cnt_o | output | CNT_W | Saturating count of bad tails |
| stat_sel_i | input | IDX_W | Unit selected for the status outputs |
| stat_pkt_o | output | CNT_W | Packet count of the selected unit |
| stat_word_o | output | CNT_W | Word count of the selected unit |
| stat_load_o | output | LOAD_W | Load of the selected unit |

## Verification
A wrong target mask or a corrupted state register shows up on unit_valid_o in the same cycle as the affected beat. It also shows as a mismatch in the word counts once that packet's tail has passed. A wrong load value or round-robin pointer stays hidden until the next arbitrated header, which then goes to the wrong unit one cycle after it arrives. The bench therefore sets up known loads and grant histories before each policy check. A watchdog fault appears only after wd_limit_i cycles, so that check samples both before and after the limit.

// File: rtl/ldb_pkg.sv
package ldb_pkg;
  typedef enum logic [1:0] {POL_STATIC = 2'd0, POL_DYNAMIC = 2'd1, POL_RROBIN = 2'd2} policy_e;
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_TAIL} state_e;

  localparam int unsigned HDR_CMD_B  = 63;
  localparam int unsigned HDR_SW_B   = 62;
  localparam int unsigned HDR_VER_LO = 58;
  localparam int unsigned HDR_UNIT_LO = 50;
  localparam int unsigned LEN_W      = 10;
  localparam logic [7:0]  ALL_UNITS  = 8'hFF;
endpackage

// File: rtl/ldb_arbiter.sv
module ldb_arbiter
  import ldb_pkg::*;
#(
  parameter int unsigned NU     = 4,
  parameter int unsigned LOAD_W = 4,
  localparam int unsigned IDX_W = (NU > 1) ? $clog2(NU) : 1
) (
  input  policy_e                       policy_i,
  input  logic [NU-1:0]                 elig_i,
  input  logic [NU-1:0][LOAD_W-1:0]     load_i,
  input  logic [IDX_W-1:0]              last_i,
  output logic                          any_o,
  output logic [IDX_W-1:0]              grant_o
);
  logic            found;
  logic [LOAD_W:0] best;
  int unsigned     idx;

  always_comb begin
    any_o   = |elig_i;
    grant_o = '0;
    found   = 1'b0;
    best    = {1'b1, {LOAD_W{1'b0}}};
    idx     = 0;
    unique case (policy_i)
      POL_DYNAMIC: begin
        for (int i = 0; i < int'(NU); i++) begin
          if (elig_i[i] && ({1'b0, load_i[i]} < best)) begin
            best    = {1'b0, load_i[i]};
            grant_o = IDX_W'(i);
          end
        end
      end
      POL_RROBIN: begin
        for (int k = 1; k <= int'(NU); k++) begin
          idx = (int'(last_i) + k) % NU;
          if (!found && elig_i[idx]) begin
            found   = 1'b1;
            grant_o = IDX_W'(idx);
          end
        end
      end
      default: begin
        for (int i = int'(NU) - 1; i >= 0; i--) begin
          if (elig_i[i]) grant_o = IDX_W'(i);
        end
      end
    endcase
  end
endmodule

// File: rtl/ldb_unit_mon.sv
module ldb_unit_mon #(
  parameter int unsigned LOAD_W = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned WD_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              good_end_i,
  input  logic              done_i,
  input  logic              fail_clr_i,
  input  logic [WD_W-1:0]   wd_limit_i,
  output logic [LOAD_W-1:0] load_o,
  output logic              failed_o,
  output logic [CNT_W-1:0]  pkt_cnt_o,
  output logic [CNT_W-1:0]  word_cnt_o
);
  localparam logic [LOAD_W-1:0] LOAD_MAX = {LOAD_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [WD_W-1:0]   WD_MAX   = {WD_W{1'b1}};

  logic [WD_W-1:0] wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o     <= '0;
      failed_o   <= 1'b0;
      pkt_cnt_o  <= '0;
      word_cnt_o <= '0;
      wd_q       <= '0;
    end else begin
      if (good_end_i && !done_i && load_o != LOAD_MAX) load_o <= load_o + 1'b1;
      else if (done_i && !good_end_i && load_o != '0)  load_o <= load_o - 1'b1;

      if (acc_i || load_o == '0 || fail_clr_i) wd_q <= '0;
      else if (!failed_o && wd_q != WD_MAX)     wd_q <= wd_q + 1'b1;

      if (fail_clr_i) failed_o <= 1'b0;
      else if (load_o != '0 && !acc_i && wd_q >= wd_limit_i) failed_o <= 1'b1;

      if (good_end_i && pkt_cnt_o != CNT_MAX) pkt_cnt_o  <= pkt_cnt_o + 1'b1;
      if (acc_i && word_cnt_o != CNT_MAX)     word_cnt_o <= word_cnt_o + 1'b1;
    end
  end

  a_r8_load_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o == '0 && done_i && !good_end_i) |=> load_o == '0);
  a_r9_fail_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(failed_o) |-> $past(load_o != '0));
  a_r11_pkt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_cnt_o == CNT_MAX) |=> (pkt_cnt_o == CNT_MAX));
  a_r11_word_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_cnt_o == CNT_MAX) |=> (word_cnt_o == CNT_MAX));
endmodule

// File: rtl/ldb_dispatcher.sv
module ldb_dispatcher
  import ldb_pkg::*;
#(
  parameter int unsigned NU      = 4,
  parameter int unsigned LOAD_W  = 4,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned WD_W    = 16,
  parameter logic [3:0]  HDR_VER = 4'h5,
  parameter logic [31:0] SYNC    = 32'hA5A5_5A5A,
  localparam int unsigned IDX_W  = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        policy_i,
  input  logic [WD_W-1:0]   wd_limit_i,
  input  logic [NU-1:0]     fail_clr_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [63:0]       in_data_i,
  output logic [NU-1:0]     unit_valid_o,
  input  logic [NU-1:0]     unit_ready_i,
  output logic [63:0]       unit_data_o,
  input  logic [NU-1:0]     unit_done_i,
  output logic [NU-1:0]     failed_o,
  output logic              framing_err_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  input  logic [IDX_W-1:0]  stat_sel_i,
  output logic [CNT_W-1:0]  stat_pkt_o,
  output logic [CNT_W-1:0]  stat_word_o,
  output logic [LOAD_W-1:0] stat_load_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  state_e                    state_q;
  logic [NU-1:0]             tgt_q, new_mask;
  logic                      arb_q;
  logic [IDX_W-1:0]          grant_q, last_q, arb_grant;
  logic [LEN_W-1:0]          len_q, rem_q;
  logic [NU-1:0][LOAD_W-1:0] load_w;
  logic [NU-1:0][CNT_W-1:0]  pkt_w, word_w;
  logic                      arb_any;

  logic       is_hdr, named_ok, bcast, use_arb, start;
  logic       fwd, all_rdy, xfer, tail_x, good_end;
  logic [7:0] unit_f;

  assign unit_f   = in_data_i[HDR_UNIT_LO +: 8];
  assign is_hdr   = in_data_i[HDR_VER_LO +: 4] == HDR_VER;
  assign named_ok = int'(unit_f) < int'(NU);
  assign bcast    = in_data_i[HDR_CMD_B] && unit_f == ALL_UNITS;
  assign use_arb  = !bcast && !((in_data_i[HDR_CMD_B] || in_data_i[HDR_SW_B]) && named_ok);
  assign start    = state_q == S_IDLE && in_valid_i && is_hdr && (!use_arb || arb_any);

  always_comb begin
    if (bcast)         new_mask = '1;
    else if (use_arb)  new_mask = NU'(1) << arb_grant;
    else               new_mask = NU'(1) << unit_f[IDX_W-1:0];
  end

  ldb_arbiter #(.NU(NU), .LOAD_W(LOAD_W)) i_arb (
    .policy_i (policy_e'(policy_i)),
    .elig_i   (~failed_o),
    .load_i   (load_w),
    .last_i   (last_q),
    .any_o    (arb_any),
    .grant_o  (arb_grant)
  );

  // cut-through: a beat moves only when every target can take it
  assign fwd          = state_q != S_IDLE;
  assign all_rdy      = &(unit_ready_i | ~tgt_q);
  assign in_ready_o   = fwd ? all_rdy : !(in_valid_i && is_hdr);
  assign xfer         = fwd && in_valid_i && all_rdy;
  assign unit_valid_o = xfer ? tgt_q : '0;
  assign unit_data_o  = in_data_i;
  assign tail_x       = xfer && state_q == S_TAIL;
  assign good_end     = tail_x && in_data_i[31:0] == SYNC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_IDLE;
      tgt_q         <= '0;
      arb_q         <= 1'b0;
      grant_q       <= '0;
      last_q        <= IDX_W'(NU - 1);
      len_q         <= '0;
      rem_q         <= '0;
      framing_err_o <= 1'b0;
      err_cnt_o     <= '0;
    end else begin
      framing_err_o <= tail_x && !good_end;
      if (tail_x && !good_end && err_cnt_o != CNT_MAX) err_cnt_o <= err_cnt_o + 1'b1;
      unique case (state_q)
        S_IDLE: if (start) begin
          tgt_q   <= new_mask;
          arb_q   <= use_arb;
          grant_q <= arb_grant;
          len_q   <= in_data_i[LEN_W-1:0];
          state_q <= S_HDR;
        end
        S_HDR: if (xfer) begin
          rem_q   <= len_q;
          state_q <= (len_q == '0) ? S_TAIL : S_DATA;
        end
        S_DATA: if (xfer) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) state_q <= S_TAIL;
        end
        S_TAIL: if (xfer) begin
          state_q <= S_IDLE;
          if (arb_q) last_q <= grant_q;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    ldb_unit_mon #(.LOAD_W(LOAD_W), .CNT_W(CNT_W), .WD_W(WD_W)) i_mon (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .acc_i      (unit_valid_o[u]),
      .good_end_i (good_end && tgt_q[u]),
      .done_i     (unit_done_i[u]),
      .fail_clr_i (fail_clr_i[u]),
      .wd_limit_i (wd_limit_i),
      .load_o     (load_w[u]),
      .failed_o   (failed_o[u]),
      .pkt_cnt_o  (pkt_w[u]),
      .word_cnt_o (word_w[u])
    );
  end

  always_comb begin
    stat_pkt_o  = '0;
    stat_word_o = '0;
    stat_load_o = '0;
    for (int u = 0; u < int'(NU); u++) begin
      if (stat_sel_i == IDX_W'(u)) begin
        stat_pkt_o  = pkt_w[u];
        stat_word_o = word_w[u];
        stat_load_o = load_w[u];
      end
    end
  end

  a_r7_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd && !tail_x) |=> $stable(tgt_q));
  a_r7_valid_on_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|unit_valid_o) |-> (in_valid_i && in_ready_o));
  a_r4_grant_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && use_arb) |-> !failed_o[arb_grant]);
  a_r10_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    framing_err_o |=> !framing_err_o);
endmodule

// File: tb/test_ldb_dispatcher.sv
`timescale 1ns/100ps
module test_ldb_dispatcher;
  localparam int NU = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    policy = 2'd0;
  logic [15:0]   wd_limit = 16'd1000;
  logic [NU-1:0] fail_clr = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [63:0]   in_data = '0;
  logic [NU-1:0] unit_valid;
  logic [NU-1:0] unit_ready = '1;
  logic [63:0]   unit_data;
  logic [NU-1:0] unit_done = '0;
  logic [NU-1:0] failed;
  logic          ferr;
  logic [CW-1:0] err_cnt;
  logic [1:0]    stat_sel = '0;
  logic [CW-1:0] stat_pkt, stat_word;
  logic [3:0]    stat_load;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  ldb_dispatcher #(.NU(NU), .LOAD_W(4), .CNT_W(CW), .WD_W(16)) i_ldb_dispatcher (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .wd_limit_i(wd_limit),
    .fail_clr_i(fail_clr), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .unit_valid_o(unit_valid), .unit_ready_i(unit_ready),
    .unit_data_o(unit_data), .unit_done_i(unit_done), .failed_o(failed),
    .framing_err_o(ferr), .err_cnt_o(err_cnt), .stat_sel_i(stat_sel),
    .stat_pkt_o(stat_pkt), .stat_word_o(stat_word), .stat_load_o(stat_load)
  );

  localparam logic [31:0] GOOD = 32'hA5A5_5A5A;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit cmd, input bit sw, input logic [7:0] unit, input int len);
    return {cmd, sw, 4'h5, unit, 16'hBEEF, 24'd0, 10'(len)};
  endfunction

  task automatic send(input logic [63:0] hdr, input int n, input logic [31:0] tail,
                      input int stall_at, output logic [NU-1:0] dest, output int hdr_wait);
    logic [63:0] w;
    hdr_wait = 0;
    dest = '0;
    for (int b = 0; b < n + 2; b++) begin
      w = (b == 0) ? hdr : (b == n + 1) ? {32'd0, tail} : {32'd0, 32'h1000 + 32'(b)};
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      if (b == stall_at) begin
        unit_ready = '0;
        repeat (2) begin
          #0.5;
          chk("R7 stall ready", {63'd0, in_ready}, 64'd0);
          chk("R7 stall valid", {60'd0, unit_valid}, 64'd0);
          @(negedge clk);
        end
        unit_ready = '1;
      end
      #0.5;
      while (!in_ready) begin
        if (b == 0) hdr_wait++;
        @(negedge clk);
        #0.5;
      end
      if (b == 0) dest = unit_valid;
      else if (unit_valid !== dest) chk("R7 target held", {60'd0, unit_valid}, {60'd0, dest});
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #0.5;
  endtask

  task automatic rd(input int u);
    @(negedge clk);
    stat_sel = 2'(u);
    #0.5;
  endtask

  task automatic clear_loads();
    @(negedge clk);
    unit_done = '1;
    repeat (16) @(negedge clk);
    unit_done = '0;
  endtask

  task automatic t_reset();
    #0.5;
    chk("reset in_ready", {63'd0, in_ready}, 64'd1);
    chk("reset unit_valid", {60'd0, unit_valid}, 64'd0);
    chk("reset failed", {60'd0, failed}, 64'd0);
    chk("reset framing", {63'd0, ferr}, 64'd0);
    chk("reset err_cnt", {58'd0, err_cnt}, 64'd0);
  endtask

  task automatic t_r1_drop();
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 64'h0000_0000_1234_5678;
    #0.5;
    chk("R1 non-header ready", {63'd0, in_ready}, 64'd1);
    chk("R1 non-header no valid", {60'd0, unit_valid}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_r2_sw();
    logic [NU-1:0] d; int hw;
    send(mk(0, 1, 8'd2, 2), 2, GOOD, -1, d, hw);
    chk("R2 sw target", {60'd0, d}, 64'b0100);
    chk("R2 latency", 64'(hw), 64'd1);
    rd(2);
    chk("R11 pkt count", {58'd0, stat_pkt}, 64'd1);
    chk("R11 word count", {58'd0, stat_word}, 64'd4);
    chk("R8 load up", {60'd0, stat_load}, 64'd1);
    rd(1);
    chk("R12 other unit words", {58'd0, stat_word}, 64'd0);
    @(negedge clk); unit_done = 4'b0100;
    @(negedge clk); unit_done = '0;
    rd(2);
    chk("R8 load down", {60'd0, stat_load}, 64'd0);
  endtask

  task automatic t_r3_cmd();
    logic [NU-1:0] d; int hw;
    send(mk(1, 0, 8'hFF, 1), 1, GOOD, -1, d, hw);
    chk("R3 broadcast", {60'd0, d}, 64'b1111);
    send(mk(1, 0, 8'd1, 1), 1, GOOD, -1, d, hw);
    chk("R3 named command", {60'd0, d}, 64'b0010);
    clear_loads();
  endtask

  task automatic t_r4_static();
    logic [NU-1:0] d; int hw;
    policy = 2'd0;
    send(mk(0, 0, 8'd0, 1), 1, GOOD, -1, d, hw);
    chk("R4 static first", {60'd0, d}, 64'b0001);
    send(mk(0, 0, 8'd3, 1), 1, GOOD, -1, d, hw);
    chk("R4 static ignores load and field", {60'd0, d}, 64'b0001);
  endtask

  task automatic t_r5_dynamic();
    logic [NU-1:0] d; int hw;
    policy = 2'd1;
    send(mk(0, 0, 8'd0, 1), 1, GOOD, -1, d, hw);
    chk("R5 least load", {60'd0, d}, 64'b0010);
    send(mk(0, 0, 8'd0, 1), 1, GOOD, -1, d, hw);
    chk("R5 tie to low index", {60'd0, d}, 64'b0100);
  endtask

  task automatic t_r6_rr();
    logic [NU-1:0] d; int hw;
    policy = 2'd2;
    send(mk(0, 0, 8'd0, 1), 1, GOOD, -1, d, hw);
    chk("R6 after last grant", {60'd0, d}, 64'b1000);
    send(mk(0, 0, 8'd0, 1), 1, GOOD, -1, d, hw);
    chk("R6 wrap", {60'd0, d}, 64'b0001);
    clear_loads();
  endtask

  task automatic t_r7_stall();
    logic [NU-1:0] d; int hw;
    send(mk(0, 1, 8'd1, 3), 3, GOOD, 2, d, hw);
    chk("R7 target", {60'd0, d}, 64'b0010);
  endtask

  task automatic t_r10_frame();
    logic [NU-1:0] d; int hw;
    logic [CW-1:0] p0; logic [3:0] l0;
    rd(0);
    p0 = stat_pkt; l0 = stat_load;
    send(mk(0, 1, 8'd0, 1), 1, 32'hDEAD_0000, -1, d, hw);
    chk("R10 pulse", {63'd0, ferr}, 64'd1);
    chk("R10 err count", {58'd0, err_cnt}, 64'd1);
    chk("R10 pkt unchanged", {58'd0, stat_pkt}, {58'd0, p0});
    chk("R10 load unchanged", {60'd0, stat_load}, {60'd0, l0});
    @(negedge clk); #0.5;
    chk("R10 pulse ends", {63'd0, ferr}, 64'd0);
    send(mk(0, 1, 8'd0, 0), 0, GOOD, -1, d, hw);
    chk("R10 resync", {60'd0, d}, 64'b0001);
    chk("R10 count kept", {58'd0, err_cnt}, 64'd1);
    clear_loads();
  endtask

  task automatic t_r9_wd();
    logic [NU-1:0] d; int hw;
    wd_limit = 16'd20;
    policy = 2'd0;
    send(mk(0, 1, 8'd0, 0), 0, GOOD, -1, d, hw);
    repeat (10) @(negedge clk);
    #0.5;
    chk("R9 not yet failed", {60'd0, failed}, 64'd0);
    repeat (20) @(negedge clk);
    #0.5;
    chk("R9 failed", {60'd0, failed}, 64'b0001);
    send(mk(0, 0, 8'd0, 0), 0, GOOD, -1, d, hw);
    chk("R9 excluded", {60'd0, d}, 64'b0010);
    clear_loads();
    @(negedge clk); fail_clr = 4'b0001;
    @(negedge clk); fail_clr = '0;
    #0.5;
    chk("R9 cleared", {60'd0, failed}, 64'd0);
    send(mk(0, 0, 8'd0, 0), 0, GOOD, -1, d, hw);
    chk("R9 readmitted", {60'd0, d}, 64'b0001);
    wd_limit = 16'd1000;
    clear_loads();
  endtask

  task automatic t_r11_sat();
    logic [NU-1:0] d; int hw;
    send(mk(0, 1, 8'd3, 70), 70, GOOD, -1, d, hw);
    rd(3);
    chk("R11 word saturate", {58'd0, stat_word}, 64'd63);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_r1_drop();
    t_r2_sw();
    t_r3_cmd();
    t_r4_static();
    t_r5_dynamic();
    t_r6_rr();
    t_r7_stall();
    t_r10_frame();
    t_r9_wd();
    t_r11_sat();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule